// File: doc/BRIEF.md
# Dual-Priority Clear-on-Read Interrupt Aggregator

This block gathers a vector of peripheral interrupt inputs and turns them into two requests for a processor core's interrupt controller: one for urgent work and one for background work. Every channel has its own enable, its own choice of priority, and, where the channel supports it, a choice between reacting to a rising or a falling transition. A qualifying transition sets a bit in the pending register of the selected priority. Each pending register raises its request line while any of its bits is set.

A service routine reads the pending register of the priority it is handling. That read returns every pending source at that priority and empties the register at the same clock edge. A transition that arrives during the reading cycle is kept for the next read. One channel is level type and works differently. Its pending bit mirrors its enabled input one cycle later, and a read never clears it. It drops only when the input condition goes away.

Configuration and pending registers are reached over a plain register bus with single-cycle read and write strobes. Read data is combinational while the read strobe is high. The inputs are assumed to be synchronous to the clock.

Top module: `irq_dual_agg`

## Requirements
- R1: After reset, the priority, enable and polarity registers and both pending registers read 0, and neither request is asserted.
- R2: The bus decodes these byte offsets: 0x00 priority select (bit=1 routes the channel to the high pending register), 0x04 enable (bit=1 enabled), 0x08 polarity (bit=1 falling edge), 0x0C high pending, 0x10 low pending. Configuration registers read back what was written, except that polarity bits of channels without edge selection (at least the level channel, bit 0 by default) read 0.
- R3: With polarity 0, a rising input edge on an enabled channel sets its pending bit at the clock edge where the new input level is first sampled. A falling edge has no effect.
- R4: With polarity 1, a falling edge sets the pending bit and a rising edge has no effect.
- R5: Edges on a disabled channel set no pending bit.
- R6: A channel's events go to the high pending register when its priority bit is 1, and to the low pending register when it is 0.
- R7: req_hi is high exactly while the high pending register is non-zero, and req_lo is high exactly while the low pending register is non-zero.
- R8: A read of a pending register returns its contents and clears all of its edge-type bits at that clock edge. The other pending register is not affected.
- R9: The level channel (bit 0 by default) shows its enabled input level in the pending register of its priority one cycle after the input changes. A read does not clear it.
- R10: An edge that arrives in the same cycle as a clearing read of its pending register stays pending after the read.
- R11: Changing a priority bit does not move bits that are already pending. Only later events use the new mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; a read of a pending register clears it at the clock edge |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | N (32) | Write data |
| bus_rdata | output | N (32) | Read data, combinational while bus_rd is high, else 0 |
| irq_in | input | N (32) | Raw synchronous interrupt inputs |
| req_hi | output | 1 | High-priority summary request |
| req_lo | output | 1 | Low-priority summary request |

## Verification
An input change driven before clock edge k is visible in the pending registers and on both request lines right after edge k, for edge and level channels alike. The bench therefore drives on the falling edge and checks at the next falling edge. A write takes effect at the edge that ends its strobe cycle. Read data is valid during the strobe cycle and reflects the contents before the clearing edge, so the bench samples it just after driving the strobe and checks the cleared state one cycle later. The same-cycle case drives an edge together with the read strobe and expects it to be missing from that read and present in the next one.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_ADDR_W = 5;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_PRIO   = 5'h00,
    RA_ENABLE = 5'h04,
    RA_POL    = 5'h08,
    RA_HI     = 5'h0C,
    RA_LO     = 5'h10
  } reg_addr_e;

  localparam int PRI_LO = 0;
  localparam int PRI_HI = 1;
  localparam int NUM_PRI = 2;
endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_agg_pkg::*;
#(
  parameter int N = 32,
  parameter logic [N-1:0] POL_OK = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] addr,
  input  logic [N-1:0]          wdata,
  output logic [N-1:0]          prio_q,
  output logic [N-1:0]          en_q,
  output logic [N-1:0]          pol_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      pol_q  <= '0;
    end else if (wr_en) begin
      case (addr)
        RA_PRIO:   prio_q <= wdata;
        RA_ENABLE: en_q   <= wdata;
        RA_POL:    pol_q  <= wdata & POL_OK;
        default: ;
      endcase
    end
  end

  // R2: configuration changes only through a write strobe
  a_r2_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(prio_q) && $stable(en_q) && $stable(pol_q)));
endmodule

// File: rtl/irq_event_detect.sv
module irq_event_detect #(
  parameter int N       = 32,
  parameter int LVL_IDX = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] en,
  input  logic [N-1:0] pol,
  output logic [N-1:0] ev,
  output logic         lvl_q
);
  localparam logic [N-1:0] LVL_MASK = {{(N-1){1'b0}}, 1'b1} << LVL_IDX;

  logic [N-1:0] prev_q;
  logic [N-1:0] ev_all;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      prev_q <= raw;
      lvl_q  <= raw[LVL_IDX] & en[LVL_IDX];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_ch
    logic rise, fall;
    assign rise      = raw[i] & ~prev_q[i];
    assign fall      = ~raw[i] & prev_q[i];
    assign ev_all[i] = en[i] & (pol[i] ? fall : rise);
  end

  assign ev = ev_all & ~LVL_MASK;

  // R3: an event only where the input differs from its previous sample
  a_r3_event_needs_change: assert property (@(posedge clk) disable iff (!rst_n)
    (ev & ~(raw ^ prev_q)) == '0);

  // R9: the level bit tracks the enabled input one cycle later
  a_r9_level_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (lvl_q == $past(raw[LVL_IDX] & en[LVL_IDX])));
endmodule

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= '0;
    else        q <= (clr ? '0 : q) | set;
  end

  // R10: events arriving with a clear stay pending
  a_r10_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (set != '0) |=> ((q & $past(set)) == $past(set)));

  // R8: a clear with no new event empties the bank
  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set == '0) |=> (q == '0));

  // R11: no bit appears without an event routed here
  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((q & ~$past(q) & ~$past(set)) == '0));
endmodule

// File: rtl/irq_dual_agg.sv
module irq_dual_agg
  import irq_agg_pkg::*;
#(
  parameter int N       = 32,
  parameter int LVL_IDX = 0,
  parameter logic [N-1:0] EDGE_SEL_OK = '1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [N-1:0]          bus_wdata,
  output logic [N-1:0]          bus_rdata,
  input  logic [N-1:0]          irq_in,
  output logic                  req_hi,
  output logic                  req_lo
);
  localparam logic [N-1:0] LVL_MASK = {{(N-1){1'b0}}, 1'b1} << LVL_IDX;
  localparam logic [N-1:0] POL_OK   = EDGE_SEL_OK & ~LVL_MASK;

  logic [N-1:0] prio_q, en_q, pol_q;
  logic [N-1:0] ev;
  logic         lvl_q;
  logic [N-1:0] lvl_vec;

  logic [NUM_PRI-1:0][N-1:0] set_pr, bank_q, view_pr;
  logic [NUM_PRI-1:0]        clr_pr;

  irq_cfg_regs #(.N(N), .POL_OK(POL_OK)) i_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .prio_q(prio_q), .en_q(en_q), .pol_q(pol_q)
  );

  irq_event_detect #(.N(N), .LVL_IDX(LVL_IDX)) i_det (
    .clk(clk), .rst_n(rst_n), .raw(irq_in), .en(en_q), .pol(pol_q),
    .ev(ev), .lvl_q(lvl_q)
  );

  assign lvl_vec = lvl_q ? LVL_MASK : '0;

  assign set_pr[PRI_HI] = ev & prio_q;
  assign set_pr[PRI_LO] = ev & ~prio_q;
  assign clr_pr[PRI_HI] = bus_rd && (bus_addr == RA_HI);
  assign clr_pr[PRI_LO] = bus_rd && (bus_addr == RA_LO);

  assign view_pr[PRI_HI] = bank_q[PRI_HI] | (lvl_vec & prio_q);
  assign view_pr[PRI_LO] = bank_q[PRI_LO] | (lvl_vec & ~prio_q);

  for (genvar p = 0; p < NUM_PRI; p++) begin : g_pri
    irq_latch_bank #(.N(N)) i_bank (
      .clk(clk), .rst_n(rst_n), .set(set_pr[p]), .clr(clr_pr[p]),
      .q(bank_q[p])
    );
  end

  assign req_hi = |view_pr[PRI_HI];
  assign req_lo = |view_pr[PRI_LO];

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        RA_PRIO:   bus_rdata = prio_q;
        RA_ENABLE: bus_rdata = en_q;
        RA_POL:    bus_rdata = pol_q;
        RA_HI:     bus_rdata = view_pr[PRI_HI];
        RA_LO:     bus_rdata = view_pr[PRI_LO];
        default:   bus_rdata = '0;
      endcase
    end
  end

  // R6: a high-routed event raises the high request next cycle
  a_r6_route_hi: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev & prio_q) != '0) |=> req_hi);

  // R6: a low-routed event raises the low request next cycle
  a_r6_route_lo: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev & ~prio_q) != '0) |=> req_lo);

  // R9: the level channel survives a read of its pending register
  a_r9_level_survives: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pr[PRI_LO] && lvl_q && !prio_q[LVL_IDX] && irq_in[LVL_IDX]
     && en_q[LVL_IDX]) |=> req_lo);
endmodule

// File: tb/test_irq_dual_agg.sv
`timescale 1ns/1ps
module test_irq_dual_agg;
  localparam int N = 32;
  localparam logic [4:0] A_PRIO = 5'h00, A_EN = 5'h04, A_POL = 5'h08,
                         A_HI = 5'h0C, A_LO = 5'h10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0, irq_in = '0;
  logic [N-1:0] bus_rdata;
  logic req_hi, req_lo;

  int n_total = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_dual_agg i_irq_dual_agg (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_in(irq_in), .req_hi(req_hi), .req_lo(req_lo)
  );

  task automatic check(input string req, input logic [N-1:0] act,
                       input logic [N-1:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [N-1:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [N-1:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic drive(input int ch, input logic val);
    @(negedge clk); irq_in[ch] = val;
    @(negedge clk);
  endtask

  task automatic drain();
    logic [N-1:0] v;
    rd(A_HI, v); rd(A_LO, v);
  endtask

  task automatic t_reset();
    logic [N-1:0] v;
    rd(A_PRIO, v); check("R1 prio", v, '0);
    rd(A_EN, v);   check("R1 enable", v, '0);
    rd(A_POL, v);  check("R1 polarity", v, '0);
    rd(A_HI, v);   check("R1 high pending", v, '0);
    rd(A_LO, v);   check("R1 low pending", v, '0);
    check("R1 requests", {30'd0, req_hi, req_lo}, '0);
  endtask

  task automatic t_regmap();
    logic [N-1:0] v;
    wr(A_PRIO, 32'hA5A5_0F0F); rd(A_PRIO, v); check("R2 prio readback", v, 32'hA5A5_0F0F);
    wr(A_EN, 32'h1234_5678);   rd(A_EN, v);   check("R2 enable readback", v, 32'h1234_5678);
    wr(A_POL, 32'hFFFF_FFFF);  rd(A_POL, v);  check("R2 polarity level bit", v, 32'hFFFF_FFFE);
    wr(A_PRIO, '0); wr(A_EN, '0); wr(A_POL, '0);
  endtask

  task automatic t_masked();
    logic [N-1:0] v;
    drive(3, 1'b1); drive(3, 1'b0);
    rd(A_LO, v); check("R5 masked low", v, '0);
    rd(A_HI, v); check("R5 masked high", v, '0);
  endtask

  task automatic t_rising();
    logic [N-1:0] v;
    wr(A_EN, 32'hFFFF_FFFE);
    drive(3, 1'b1);
    check("R7 req_lo after rise", {31'd0, req_lo}, 1);
    check("R7 req_hi idle", {31'd0, req_hi}, 0);
    drive(3, 1'b0);
    rd(A_LO, v); check("R3 rising latched", v, 32'h8);
    check("R8 req_lo cleared", {31'd0, req_lo}, 0);
    rd(A_LO, v); check("R3 falling ignored", v, '0);
  endtask

  task automatic t_falling();
    logic [N-1:0] v;
    wr(A_POL, 32'h200);
    drive(9, 1'b1);
    check("R4 rise ignored", {31'd0, req_lo}, 0);
    drive(9, 1'b0);
    check("R4 fall raises", {31'd0, req_lo}, 1);
    rd(A_LO, v); check("R4 falling latched", v, 32'h200);
    wr(A_POL, '0);
  endtask

  task automatic t_priority();
    logic [N-1:0] v;
    wr(A_PRIO, 32'h1000);
    drive(12, 1'b1); drive(12, 1'b0);
    drive(4, 1'b1);  drive(4, 1'b0);
    check("R6 req_hi", {31'd0, req_hi}, 1);
    check("R6 req_lo", {31'd0, req_lo}, 1);
    rd(A_HI, v); check("R6 high content", v, 32'h1000);
    check("R8 req_hi cleared", {31'd0, req_hi}, 0);
    check("R8 other bank kept", {31'd0, req_lo}, 1);
    rd(A_LO, v); check("R6 low content", v, 32'h10);
  endtask

  task automatic t_remap();
    logic [N-1:0] v;
    wr(A_PRIO, '0);
    drive(20, 1'b1); drive(20, 1'b0);
    wr(A_PRIO, 32'h10_0000);
    rd(A_HI, v); check("R11 not moved to high", v, '0);
    rd(A_LO, v); check("R11 stays low", v, 32'h10_0000);
    wr(A_PRIO, '0);
  endtask

  task automatic t_same_cycle();
    logic [N-1:0] v;
    drive(5, 1'b1); drive(5, 1'b0);
    @(negedge clk); bus_rd = 1'b1; bus_addr = A_LO; irq_in[7] = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
    check("R10 read content", v, 32'h20);
    rd(A_LO, v); check("R10 edge kept", v, 32'h80);
    drive(7, 1'b0);
  endtask

  task automatic t_level();
    logic [N-1:0] v;
    wr(A_EN, 32'hFFFF_FFFF);
    drive(0, 1'b1);
    check("R9 level raises req_lo", {31'd0, req_lo}, 1);
    rd(A_LO, v); check("R9 level read", v, 32'h1);
    rd(A_LO, v); check("R9 level not cleared", v, 32'h1);
    drive(0, 1'b0);
    check("R9 level drops", {31'd0, req_lo}, 0);
    rd(A_LO, v); check("R9 level gone", v, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regmap();
    t_masked();
    t_rising();
    t_falling();
    t_priority();
    t_remap();
    t_same_cycle();
    t_level();
    drain();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule